// File: doc/BRIEF.md
# Dual-Format Serial Register Front End

This block is the serial slave port of a multi-channel converter. A shift clock moves command and data bits in on a data-in pin. A shared select/load pin and a static format strap decide how a frame is delimited. The block holds the shift register, hands a parallel word to a downstream decoder with a one-cycle transfer strobe, and drives a data-out pin with an output enable. That pin carries either the shifted-out contents or a ready/busy flag, which comes from an external busy input.

With the strap high, frames are 16 bits long, delimited by an active-low chip select, and shifted LSB first. When chip select falls, the shift clock level chooses the mode. A high clock opens a data frame. A low clock opens a status query, and the ready flag then appears on data-out. With the strap low, the register is 14 bits wide and shifts MSB first without a frame. A high pulse on the load pin copies the register to the parallel output.

All pins are sampled by a faster system clock through two-stage synchronizers. Edges are found by comparing the synchronized value with the value one system cycle earlier.

Top module: `serial_dac_if`

## Requirements
- R1: With the strap high (`fmt_cs_i`=1), a frame opened with the shift clock high captures `sdi_i` on each shift-clock rising edge. The first bit goes to word bit 0 and the last bit to word bit 15. When chip select rises after exactly 16 bits, `word_o` takes the 16-bit value.
- R2: With the strap high, a frame with a bit count other than 16 produces no strobe and leaves `word_o` unchanged.
- R3: With the strap high, `sdo_oe_o` is 0 whenever the synchronized chip select is high, and 1 while it is low.
- R4: In a data frame, `sdo_o` presents the register contents from before the frame, LSB first. The first bit is valid before the first shift-clock rising edge, and each later bit appears after a shift-clock falling edge.
- R5: A chip-select fall while the shift clock is low enters status mode. In status mode `sdo_o` equals the inverted busy input (1 = ready, 0 = busy), and shift-clock edges do not alter the register.
- R6: A chip-select rise leaves data or status mode whatever the shift-clock level. Ending a status frame gives no strobe.
- R7: With the strap low, each shift-clock rising edge shifts `sdi_i` into bit 0 of a 14-bit register, moving older bits toward bit 13. A rising edge on the load pin copies the register to `word_o[13:0]` and clears `word_o[15:14]`.
- R8: With the strap low, `sdo_oe_o` is always 1. `sdo_o` takes register bit 13 (MSB first) on each shift-clock falling edge.
- R9: With the strap low and busy high, `sdo_o` is 0 (the busy flag).
- R10: `word_vld_o` is a single-cycle pulse. It occurs only in the second system cycle after the synchronized chip-select/load input rises.
- R11: After reset, `word_o` and the register are zero and `word_vld_o` is 0. The chip-select/load synchronizer resets to high, as an undriven pulled-up pin would read, so reset causes no false chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_cs_i | input | 1 | Format strap: 1 = 16-bit chip-select framing, 0 = 14-bit load framing |
| sck_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in |
| csld_i | input | 1 | Active-low chip select (strap high) or active-high load pulse (strap low) |
| busy_i | input | 1 | Busy indication from the write engine |
| sdo_o | output | 1 | Serial data out or ready/busy flag |
| sdo_oe_o | output | 1 | Output enable for the data-out pad; 0 means high impedance |
| word_o | output | 16 | Parallel word for the downstream decoder |
| word_vld_o | output | 1 | One-cycle transfer strobe |

## Verification
Chip-select frames are driven with bit counts of 0, 15, 16 and 17 under known and random data. The exact-16 rule is checked by whether a strobe follows, and the LSB-first ordering is checked by reading the previous word back on data-out. Status frames are opened with the clock low while busy toggles and the shift clock keeps running. The frame that follows shows that the register was untouched, which tells the two chip-select modes apart. In load framing, random words of varied length are loaded under busy and idle conditions, which separates the MSB-first path and the busy override from the chip-select logic.

// File: rtl/sdif_pkg.sv
package sdif_pkg;

    typedef enum logic [1:0] {
        FM_IDLE   = 2'd0,
        FM_SHIFT  = 2'd1,
        FM_STATUS = 2'd2
    } frame_mode_e;

    typedef struct packed {
        logic sck;
        logic sdi;
        logic csld;
        logic busy;
    } pins_t;

    localparam int PIN_COUNT = 4;
    localparam logic [PIN_COUNT-1:0] PIN_RST_VAL = 4'b0010;

    function automatic logic rise_of(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

    function automatic logic fall_of(input logic now_v, input logic prev_v);
        return ~now_v & prev_v;
    endfunction

endpackage

// File: rtl/sdif_sync.sv
module sdif_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] s_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d_i[b]};
            end
        end
        assign s_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/sdif_frame.sv
module sdif_frame
    import sdif_pkg::*;
#(
    parameter int CS_LEN = 16,
    parameter int LD_LEN = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fmt_cs_i,
    input  logic              sdi_i,
    input  logic              sck_prev_i,
    input  logic              sck_rise_i,
    input  logic              csld_rise_i,
    input  logic              csld_fall_i,
    output frame_mode_e       mode_o,
    output logic [CS_LEN-1:0] shreg_o,
    output logic [CS_LEN-1:0] word_o,
    output logic              word_vld_o
);

    localparam int CNT_W   = $clog2(CS_LEN + 2);
    localparam int PAD_W   = CS_LEN - LD_LEN;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CS_LEN);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CS_LEN + 1);

    frame_mode_e       mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CS_LEN-1:0] shreg_q;
    logic [CS_LEN-1:0] word_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= FM_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            word_q  <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (fmt_cs_i) begin
                if (csld_fall_i) begin
                    mode_q <= sck_prev_i ? FM_SHIFT : FM_STATUS;
                    cnt_q  <= '0;
                end else if (csld_rise_i) begin
                    if (mode_q == FM_SHIFT && cnt_q == CNT_FULL) begin
                        word_q <= shreg_q;
                        vld_q  <= 1'b1;
                    end
                    mode_q <= FM_IDLE;
                end else if (mode_q == FM_SHIFT && sck_rise_i) begin
                    shreg_q <= {sdi_i, shreg_q[CS_LEN-1:1]};
                    if (cnt_q != CNT_OVER) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else begin
                mode_q <= FM_IDLE;
                if (sck_rise_i) begin
                    shreg_q <= {{PAD_W{1'b0}}, shreg_q[LD_LEN-2:0], sdi_i};
                end
                if (csld_rise_i) begin
                    word_q <= shreg_q;
                    vld_q  <= 1'b1;
                end
            end
        end
    end

    assign mode_o     = mode_q;
    assign shreg_o    = shreg_q;
    assign word_o     = word_q;
    assign word_vld_o = vld_q;

endmodule

// File: rtl/sdif_sdo.sv
module sdif_sdo
    import sdif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fmt_cs_i,
    input  frame_mode_e mode_i,
    input  logic        csld_i,
    input  logic        csld_fall_i,
    input  logic        sck_fall_i,
    input  logic        busy_i,
    input  logic        lsb_i,
    input  logic        msb_i,
    output logic        sdo_o,
    output logic        sdo_oe_o
);

    logic sdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b0;
        end else if (fmt_cs_i) begin
            if (csld_fall_i || (mode_i == FM_SHIFT && sck_fall_i)) begin
                sdo_q <= lsb_i;
            end
        end else if (sck_fall_i) begin
            sdo_q <= msb_i;
        end
    end

    always_comb begin
        if (fmt_cs_i) begin
            sdo_oe_o = ~csld_i;
            sdo_o    = (mode_i == FM_STATUS) ? ~busy_i : sdo_q;
        end else begin
            sdo_oe_o = 1'b1;
            sdo_o    = busy_i ? 1'b0 : sdo_q;
        end
    end

endmodule

// File: rtl/serial_dac_if.sv
module serial_dac_if
    import sdif_pkg::*;
#(
    parameter int CS_LEN      = 16,
    parameter int LD_LEN      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fmt_cs_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              csld_i,
    input  logic              busy_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [CS_LEN-1:0] word_o,
    output logic              word_vld_o
);

    pins_t             pins_raw;
    pins_t             pins_s;
    logic [PIN_COUNT-1:0] pins_s_vec;
    logic              sck_p;
    logic              csld_p;
    logic              sck_rise;
    logic              sck_fall;
    logic              csld_rise;
    logic              csld_fall;
    frame_mode_e       mode;
    logic [CS_LEN-1:0] shreg;

    assign pins_raw = '{sck: sck_i, sdi: sdi_i, csld: csld_i, busy: busy_i};

    sdif_sync #(
        .WIDTH   (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST_VAL)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .s_o (pins_s_vec)
    );

    assign pins_s = pins_t'(pins_s_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= PIN_RST_VAL[3];
            csld_p <= PIN_RST_VAL[1];
        end else begin
            sck_p  <= pins_s.sck;
            csld_p <= pins_s.csld;
        end
    end

    assign sck_rise  = rise_of(pins_s.sck, sck_p);
    assign sck_fall  = fall_of(pins_s.sck, sck_p);
    assign csld_rise = rise_of(pins_s.csld, csld_p);
    assign csld_fall = fall_of(pins_s.csld, csld_p);

    sdif_frame #(
        .CS_LEN (CS_LEN),
        .LD_LEN (LD_LEN)
    ) i_frame (
        .clk         (clk),
        .rst         (rst),
        .fmt_cs_i    (fmt_cs_i),
        .sdi_i       (pins_s.sdi),
        .sck_prev_i  (sck_p),
        .sck_rise_i  (sck_rise),
        .csld_rise_i (csld_rise),
        .csld_fall_i (csld_fall),
        .mode_o      (mode),
        .shreg_o     (shreg),
        .word_o      (word_o),
        .word_vld_o  (word_vld_o)
    );

    sdif_sdo i_sdo (
        .clk         (clk),
        .rst         (rst),
        .fmt_cs_i    (fmt_cs_i),
        .mode_i      (mode),
        .csld_i      (pins_s.csld),
        .csld_fall_i (csld_fall),
        .sck_fall_i  (sck_fall),
        .busy_i      (pins_s.busy),
        .lsb_i       (shreg[0]),
        .msb_i       (shreg[LD_LEN-1]),
        .sdo_o       (sdo_o),
        .sdo_oe_o    (sdo_oe_o)
    );

endmodule

// File: rtl/sdif_checker.sv
module sdif_checker
    import sdif_pkg::*;
#(
    parameter int CS_LEN = 16,
    parameter int LD_LEN = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fmt_cs_i,
    input  logic              csld_s,
    input  logic              busy_s,
    input  frame_mode_e       mode,
    input  logic              sdo_o,
    input  logic              sdo_oe_o,
    input  logic [CS_LEN-1:0] word_o,
    input  logic              word_vld_o
);

    // R10: strobe lasts a single system cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_vld_o |=> !word_vld_o);

    // R10: strobe only after a synchronized rise of chip select / load
    a_r10_after_rise: assert property (@(posedge clk) disable iff (rst)
        word_vld_o |-> ($past(csld_s) && !$past(csld_s, 2)));

    // R3: pad disabled while chip select is high
    a_r3_hiz: assert property (@(posedge clk) disable iff (rst)
        (fmt_cs_i && csld_s) |-> !sdo_oe_o);

    // R5: status mode shows the inverted busy flag
    a_r5_status_flag: assert property (@(posedge clk) disable iff (rst)
        (fmt_cs_i && mode == FM_STATUS) |-> (sdo_o == !busy_s));

    // R9: busy forces data-out low in load framing
    a_r9_busy_low: assert property (@(posedge clk) disable iff (rst)
        (!fmt_cs_i && busy_s) |-> (!sdo_o && sdo_oe_o));

    // R7: load framing never sets the two top word bits on transfer
    a_r7_word_width: assert property (@(posedge clk) disable iff (rst)
        (word_vld_o && !fmt_cs_i) |-> (word_o[CS_LEN-1:LD_LEN] == '0));

endmodule

bind serial_dac_if sdif_checker #(
    .CS_LEN (CS_LEN),
    .LD_LEN (LD_LEN)
) i_sdif_checker (
    .clk        (clk),
    .rst        (rst),
    .fmt_cs_i   (fmt_cs_i),
    .csld_s     (pins_s.csld),
    .busy_s     (pins_s.busy),
    .mode       (mode),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
);

// File: tb/test_serial_dac_if.sv
`timescale 1ns/1ps
module test_serial_dac_if;

    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_cs = 1'b1;
    logic        sck = 1'b1;
    logic        sdi = 1'b0;
    logic        csld = 1'b1;
    logic        busy = 1'b0;
    logic        sdo;
    logic        sdo_oe;
    logic [15:0] word;
    logic        word_vld;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    int wide_pulses = 0;
    logic prev_vld = 1'b0;
    logic [15:0] m16;
    logic [13:0] m14;
    logic [15:0] last_word;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_dac_if i_serial_dac_if (
        .clk        (clk),
        .rst        (rst),
        .fmt_cs_i   (fmt_cs),
        .sck_i      (sck),
        .sdi_i      (sdi),
        .csld_i     (csld),
        .busy_i     (busy),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe),
        .word_o     (word),
        .word_vld_o (word_vld)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (word_vld) strobes++;
            if (word_vld && prev_vld) wide_pulses++;
            prev_vld <= word_vld;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cs_shift(input logic [15:0] m, input logic d);
        return {d, m[15:1]};
    endfunction

    function automatic logic [13:0] ld_shift(input logic [13:0] m, input logic d);
        return {m[12:0], d};
    endfunction

    task automatic do_reset(input logic fmt);
        rst = 1'b1;
        fmt_cs = fmt;
        csld = fmt;
        sck = fmt;
        sdi = 1'b0;
        busy = 1'b0;
        wclk(5);
        rst = 1'b0;
        wclk(6);
        m16 = '0;
        m14 = '0;
        last_word = '0;
    endtask

    // data frame in chip-select framing; bits beyond 16 taken from extra
    task automatic cs_data_frame(input int nbits, input logic [15:0] data,
                                 input logic [15:0] extra);
        int s0;
        logic d;
        s0 = strobes;
        sck = 1'b1;
        wclk(H);
        csld = 1'b0;
        wclk(H);
        check(sdo_oe == 1'b1, "R3 oe in frame", sdo_oe, 1);
        for (int k = 0; k < nbits; k++) begin
            d = (k < 16) ? data[k] : extra[k % 16];
            sck = 1'b0;
            sdi = d;
            wclk(H);
            check(sdo == m16[0], "R4 readout bit", sdo, m16[0]);
            sck = 1'b1;
            wclk(H);
            m16 = cs_shift(m16, d);
        end
        csld = 1'b1;
        wclk(H);
        check(sdo_oe == 1'b0, "R3 oe after frame", sdo_oe, 0);
        if (nbits == 16) begin
            last_word = m16;
            check(strobes == s0 + 1, "R1 strobe count", strobes - s0, 1);
            check(word == m16, "R1 captured word", word, m16);
        end else begin
            check(strobes == s0, "R2 no strobe on short/long frame", strobes - s0, 0);
            check(word == last_word, "R2 word kept", word, last_word);
        end
    endtask

    task automatic cs_status_frame(input int toggles);
        int s0;
        s0 = strobes;
        sck = 1'b0;
        wclk(H);
        csld = 1'b0;
        wclk(H);
        for (int k = 0; k < toggles; k++) begin
            busy = $urandom_range(0, 1);
            sdi = $urandom_range(0, 1);
            sck = ~sck;
            wclk(H);
            check(sdo == ~busy, "R5 status flag", sdo, ~busy);
            check(sdo_oe == 1'b1, "R3 oe in status", sdo_oe, 1);
        end
        sck = $urandom_range(0, 1);
        busy = 1'b0;
        wclk(H);
        csld = 1'b1;
        wclk(H);
        check(sdo_oe == 1'b0, "R6 status left", sdo_oe, 0);
        check(strobes == s0, "R6 no strobe after status", strobes - s0, 0);
    endtask

    task automatic ld_frame(input int nbits, input logic [15:0] data, input bit with_busy);
        int s0;
        logic d;
        s0 = strobes;
        for (int k = 0; k < nbits; k++) begin
            d = data[k % 16];
            sck = 1'b0;
            sdi = d;
            wclk(H);
            check(sdo == m14[13], "R8 MSB-first readout", sdo, m14[13]);
            check(sdo_oe == 1'b1, "R8 oe always on", sdo_oe, 1);
            sck = 1'b1;
            wclk(H);
            m14 = ld_shift(m14, d);
        end
        if (with_busy) begin
            busy = 1'b1;
            wclk(H);
            check(sdo == 1'b0, "R9 busy flag", sdo, 0);
            busy = 1'b0;
            wclk(H);
        end
        csld = 1'b1;
        wclk(H);
        csld = 1'b0;
        wclk(H);
        check(strobes == s0 + 1, "R7 load strobe", strobes - s0, 1);
        check(word == {2'b00, m14}, "R7 loaded word", word, {2'b00, m14});
    endtask

    initial begin
        int unsigned seed_v;
        int n;
        seed_v = $urandom(32'd2024);

        do_reset(1'b1);
        check(word == 16'h0, "R11 word after reset", word, 0);
        check(word_vld == 1'b0, "R11 strobe after reset", word_vld, 0);
        check(sdo_oe == 1'b0, "R11 R3 oe after reset", sdo_oe, 0);
        check(strobes == 0, "R11 no spurious strobe", strobes, 0);

        cs_data_frame(16, 16'hA5C3, 16'h0);
        cs_data_frame(16, 16'h1E2D, 16'h0);
        cs_data_frame(15, 16'hFFFF, 16'h0);
        cs_data_frame(17, 16'h0F0F, 16'hFFFF);
        cs_data_frame(0, 16'h0, 16'h0);
        cs_status_frame(6);
        cs_data_frame(16, 16'h8001, 16'h0);
        cs_status_frame(3);
        cs_data_frame(16, 16'h7FFE, 16'h0);

        for (int i = 0; i < 24; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                cs_status_frame($urandom_range(1, 5));
            end else begin
                case ($urandom_range(0, 4))
                    0: n = 15;
                    1: n = 17;
                    2: n = $urandom_range(0, 20);
                    default: n = 16;
                endcase
                cs_data_frame(n, 16'($urandom), 16'($urandom));
            end
        end

        do_reset(1'b0);
        check(sdo_oe == 1'b1, "R8 oe after reset", sdo_oe, 1);
        check(sdo == 1'b0, "R11 sdo after reset", sdo, 0);
        check(word_vld == 1'b0, "R11 load strobe after reset", word_vld, 0);
        ld_frame(14, 16'h2AAA, 1'b0);
        ld_frame(14, 16'h3FFF, 1'b1);
        ld_frame(5, 16'h0015, 1'b1);
        for (int i = 0; i < 16; i++) begin
            ld_frame($urandom_range(1, 20), 16'($urandom), 1'($urandom_range(0, 1)));
        end

        check(wide_pulses == 0, "R10 single-cycle strobe", wide_pulses, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule